// File: doc/BRIEF.md
# Slot Interrupt Aggregation Controller

This block gathers the interrupt requests of four plug-in slots, each of which drives two request lines, and folds them into one interrupt output toward the host. Software programs one 8-bit control register per slot. Each register enables each of the slot's two lines and chooses, per line, between level behaviour and edge behaviour. A 16-bit status register reports the latched request state of every line. It also reports one timeout flag per slot, which an outside timer raises with a single-cycle pulse.

Level-mode lines hold the host output high for as long as any of them is latched. An edge-mode line that becomes active does not hold the output. Instead it flips the output away from its held value for exactly one cycle. Request lines are asynchronous and pass through a two-stage synchronizer before edge detection. Software clears latched interrupt bits and timeout flags by writing ones to the status register.

Top module: `slotirq_agg`

## Requirements
- R1: After reset, every control register and the status register read 0x0000, and hostIrq is low.
- R2: Registers are decoded from regAddr[3:1], and regAddr[0] is ignored. Byte offsets 0x2, 0x4, 0x6 and 0x8 hold the control registers of slots 0 to 3 (slot = offset/2 - 1), read back in bits 7:0 with bits 15:8 reading zero. Offset 0xC is the status register. Offsets 0x0, 0xA and 0xE always read zero, and writes to them change nothing.
- R3: In a control register, bit 6+n enables line n of the slot (n = 0 or 1) and bit 4+n selects edge mode for that line. Bits 3:0 are stored and read back, but do not affect interrupt behaviour.
- R4: Status bit 2*slot+n follows an enabled request line intReq[2*slot+n]. A rise of the line sets the bit and a fall clears it. The new value is readable in the third clock cycle after the input changes.
- R5: While a line's enable bit is clear, changes on that line are ignored and its status bit keeps its value.
- R6: hostIrq is high while any set status bit 2*slot+n has its edge-mode bit clear. It returns low once no such bit remains, unless an edge pulse is in progress.
- R7: When an edge-mode line's status bit goes from 0 to 1, hostIrq is inverted for exactly one cycle, in the same cycle the status bit first reads 1. Edge-mode bits never hold hostIrq.
- R8: Writing 1 to status bit 2*slot+n clears it on the next clock. A same-cycle rise on that line wins over the clear.
- R9: A pulse on timeoutPulse[s] sets status bit 12+s. Writing 1 to that bit clears it, and a same-cycle pulse wins over the clear.
- R10: Status bits 11:8 always read zero, and writing to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register byte offset |
| regWrite | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| intReq | input | 8 | Asynchronous request lines, bit 2*slot+line |
| timeoutPulse | input | 4 | Per-slot timeout pulse, synchronous |
| hostIrq | output | 1 | Aggregated host interrupt |

## Verification
Assertions check on every cycle that a disabled line never sets its status bit. They also check that a write-one clear of an interrupt or timeout bit takes effect unless a same-cycle set competes, that a timeout pulse always latches, and that no two register write strobes fire together. Only the bench's scenarios can show the aggregate output: the one-cycle inversion for an edge line, the held level for level lines, and their interaction when an edge pulse lands while a level source is active. The three-cycle synchronizer latency and the read-back of the whole register map are likewise shown only by the bench, which compares every cycle against a model.

// File: rtl/slotirq_pkg.sv
package slotirq_pkg;
  localparam int SLOTS    = 4;
  localparam int LINES    = 2;
  localparam int REQS     = SLOTS * LINES;
  localparam int DATA_W   = 16;
  localparam int CTRL_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int EDGE_BIT = 4;
  localparam int EN_BIT   = 6;
  localparam int ERR_BASE = 8;
  localparam int ERR_W    = 4;
  localparam int TO_BASE  = 12;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_CTRL,
    RD_STATUS
  } rdsel_e;

  typedef struct packed {
    logic [SLOTS-1:0]  ctrlWe;
    logic              statusWe;
    rdsel_e            rdSel;
    logic [SLOT_W-1:0] rdSlot;
  } strobe_t;
endpackage

// File: rtl/slotirq_ctrl.sv
module slotirq_ctrl
  import slotirq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  output strobe_t           strb
);
  localparam logic [2:0] WORD_STATUS = 3'd6;

  logic [2:0] word;
  logic [2:0] wordMinus1;
  logic       isCtrl;

  assign word       = regAddr[3:1];
  assign wordMinus1 = word - 3'd1;
  assign isCtrl     = (word >= 3'd1) && (word <= 3'(SLOTS));

  for (genvar s = 0; s < SLOTS; s++) begin : g_we
    assign strb.ctrlWe[s] = regWrite && (word == 3'(s + 1));
  end

  assign strb.statusWe = regWrite && (word == WORD_STATUS);
  assign strb.rdSlot   = wordMinus1[SLOT_W-1:0];

  always_comb begin
    if (isCtrl)                    strb.rdSel = RD_CTRL;
    else if (word == WORD_STATUS)  strb.rdSel = RD_STATUS;
    else                           strb.rdSel = RD_ZERO;
  end

  // R2
  always_comb begin
    one_strobe_chk: assert ($onehot0({strb.ctrlWe, strb.statusWe}));
  end
endmodule

// File: rtl/slotirq_dpath.sv
module slotirq_dpath
  import slotirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REQS-1:0]   intReq,
  input  logic [SLOTS-1:0]  timeoutPulse,
  output logic [DATA_W-1:0] rdData,
  output logic              hostIrq
);
  logic [CTRL_W-1:0] ctrlQ [SLOTS];
  logic [REQS-1:0]   syncQ [SYNC_STAGES];
  logic [REQS-1:0]   prevQ;
  logic [REQS-1:0]   reqS;
  logic [REQS-1:0]   enMask, edgeMask;
  logic [REQS-1:0]   rise, fall, clrInt;
  logic [REQS-1:0]   intStat;
  logic [SLOTS-1:0]  toStat, clrTo;
  logic              pulseQ;
  logic              levelAny;
  logic [DATA_W-1:0] statusWord;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               ctrlQ[s] <= '0;
      else if (strb.ctrlWe[s]) ctrlQ[s] <= wrData[CTRL_W-1:0];
    end
    for (genvar n = 0; n < LINES; n++) begin : g_line
      assign enMask[s*LINES+n]   = ctrlQ[s][EN_BIT+n];
      assign edgeMask[s*LINES+n] = ctrlQ[s][EDGE_BIT+n];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_STAGES; k++) syncQ[k] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= intReq;
      for (int k = 1; k < SYNC_STAGES; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= reqS;
    end
  end

  assign reqS   = syncQ[SYNC_STAGES-1];
  assign rise   = reqS & ~prevQ & enMask;
  assign fall   = ~reqS & prevQ & enMask;
  assign clrInt = strb.statusWe ? wrData[REQS-1:0] : '0;
  assign clrTo  = strb.statusWe ? wrData[TO_BASE +: SLOTS] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= '0;
      toStat  <= '0;
      pulseQ  <= 1'b0;
    end else begin
      intStat <= rise | (intStat & ~fall & ~clrInt);
      toStat  <= timeoutPulse | (toStat & ~clrTo);
      pulseQ  <= |(rise & edgeMask & ~intStat);
    end
  end

  assign levelAny   = |(intStat & ~edgeMask);
  assign hostIrq    = levelAny ^ pulseQ;
  assign statusWord = {toStat, {ERR_W{1'b0}}, intStat};

  always_comb begin
    unique case (strb.rdSel)
      RD_CTRL:   rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ[strb.rdSlot]};
      RD_STATUS: rdData = statusWord;
      default:   rdData = '0;
    endcase
  end

  for (genvar i = 0; i < REQS; i++) begin : g_int_chk
    // R5
    en_off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !enMask[i] |=> !$rose(intStat[i]));
    // R8
    int_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.statusWe && wrData[i] && !(reqS[i] && !prevQ[i] && enMask[i])) |=> !intStat[i]);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_to_chk
    // R9
    to_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      timeoutPulse[s] |=> toStat[s]);
    // R9
    to_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.statusWe && wrData[TO_BASE+s] && !timeoutPulse[s]) |=> !toStat[s]);
  end
endmodule

// File: rtl/slotirq_agg.sv
module slotirq_agg
  import slotirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [REQS-1:0]   intReq,
  input  logic [SLOTS-1:0]  timeoutPulse,
  output logic              hostIrq
);
  strobe_t strb;

  slotirq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrite(regWrite),
    .strb    (strb)
  );

  slotirq_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (regWrData),
    .intReq      (intReq),
    .timeoutPulse(timeoutPulse),
    .rdData      (regRdData),
    .hostIrq     (hostIrq)
  );
endmodule

// File: tb/slotirq_agg_test.sv
`timescale 1ns/1ps
module slotirq_agg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrite = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  intReq = '0;
  logic [3:0]  timeoutPulse = '0;
  logic        hostIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit autoCmp = 1'b0;

  always #5 clk = ~clk;

  slotirq_agg uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWrData(regWrData), .regRdData(regRdData), .intReq(intReq),
    .timeoutPulse(timeoutPulse), .hostIrq(hostIrq)
  );

  // ---------------- reference model built from the requirements
  logic [7:0] mCtrl [4];
  logic [7:0] mS1, mS2, mPrev, mInt;
  logic [3:0] mTo;
  logic       mPulse;

  function automatic logic [7:0] enOf();
    logic [7:0] m;
    for (int s = 0; s < 4; s++) begin
      m[2*s]   = mCtrl[s][6];   // R3 enable bits 6,7
      m[2*s+1] = mCtrl[s][7];
    end
    return m;
  endfunction

  function automatic logic [7:0] edgeOf();
    logic [7:0] m;
    for (int s = 0; s < 4; s++) begin
      m[2*s]   = mCtrl[s][4];   // R3 edge bits 4,5
      m[2*s+1] = mCtrl[s][5];
    end
    return m;
  endfunction

  function automatic logic [15:0] expRead(input logic [3:0] a);
    logic [2:0] w = a[3:1];
    if (w >= 3'd1 && w <= 3'd4) return {8'h00, mCtrl[w-3'd1]};
    if (w == 3'd6) return {mTo, 4'h0, mInt};
    return 16'h0000;
  endfunction

  function automatic logic expIrq();
    return (|(mInt & ~edgeOf())) ^ mPulse;
  endfunction

  always @(posedge clk) begin
    logic [7:0]  en, ed, rise, fall;
    logic [15:0] clr;
    if (!rstN) begin
      for (int s = 0; s < 4; s++) mCtrl[s] = '0;
      mS1 = '0; mS2 = '0; mPrev = '0; mInt = '0; mTo = '0; mPulse = 1'b0;
    end else begin
      en   = enOf();
      ed   = edgeOf();
      rise = mS2 & ~mPrev & en;
      fall = ~mS2 & mPrev & en;
      clr  = (regWrite && regAddr[3:1] == 3'd6) ? regWrData : 16'h0;
      mPulse = |(rise & ed & ~mInt);
      mInt   = rise | (mInt & ~fall & ~clr[7:0]);
      mTo    = timeoutPulse | (mTo & ~clr[15:12]);
      if (regWrite && regAddr[3:1] >= 3'd1 && regAddr[3:1] <= 3'd4)
        mCtrl[regAddr[3:1]-3'd1] = regWrData[7:0];
      mPrev = mS2; mS2 = mS1; mS1 = intReq;
    end
  end

  // ---------------- checking
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (autoCmp && rstN) begin
      chk("R2/R4 model read", regRdData, expRead(regAddr));
      chk("R6/R7 model hostIrq", {15'h0, hostIrq}, {15'h0, expIrq()});
    end
  end

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    drv();
    regAddr = a; regWrite = 1'b1; regWrData = d;
    @(posedge clk); #2;
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic waitSync();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), d);
      chk("R1 reset register", d, 16'h0000);
    end
    chk("R1 reset hostIrq", {15'h0, hostIrq}, 16'h0);
    autoCmp = 1'b1;

    // R2 control readback, R3 low bits stored
    wr(4'h2, 16'hFF0F); wr(4'h4, 16'h0003); wr(4'h6, 16'h00A5); wr(4'h8, 16'h003C);
    rd(4'h2, d); chk("R2 slot0 ctrl (upper byte zero) R3 low bits", d, 16'h000F);
    rd(4'h5, d); chk("R2 slot1 ctrl, addr bit0 ignored", d, 16'h0003);
    rd(4'h6, d); chk("R2 slot2 ctrl", d, 16'h00A5);
    rd(4'h8, d); chk("R2 slot3 ctrl", d, 16'h003C);
    wr(4'h0, 16'hFFFF); wr(4'hA, 16'hFFFF); wr(4'hE, 16'hFFFF);
    rd(4'h0, d); chk("R2 offset 0x0 reads zero", d, 16'h0000);
    rd(4'hA, d); chk("R2 offset 0xA reads zero", d, 16'h0000);
    rd(4'hE, d); chk("R2 offset 0xE reads zero", d, 16'h0000);
    rd(4'hC, d); chk("R2 ignored writes leave status", d, 16'h0000);
    for (int s = 0; s < 4; s++) wr(4'(2*s+2), 16'h0000);

    // R3/R4/R6 level line: slot1 line0 enabled, level mode
    wr(4'h4, 16'h0040);
    drv(); intReq[2] = 1'b1; regAddr = 4'hC;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 status not yet set after two edges", regRdData, 16'h0000);
    @(negedge clk);
    chk("R4 status bit2 set on third edge", regRdData, 16'h0004);
    chk("R6 level hostIrq high", {15'h0, hostIrq}, 16'h1);
    drv(); intReq[2] = 1'b0;
    waitSync();
    chk("R4 status bit2 cleared by fall", regRdData, 16'h0000);
    chk("R6 hostIrq low when no level bit", {15'h0, hostIrq}, 16'h0);

    // R5 disabled line ignored (slot1 line1 enable clear)
    drv(); intReq[3] = 1'b1;
    waitSync(); repeat (2) @(negedge clk);
    rd(4'hC, d); chk("R5 disabled line status", d, 16'h0000);
    chk("R5 disabled line hostIrq", {15'h0, hostIrq}, 16'h0);
    drv(); intReq[3] = 1'b0;
    repeat (4) @(negedge clk);

    // R7 edge line: slot2 line0 enabled + edge
    wr(4'h6, 16'h0050);
    drv(); intReq[4] = 1'b1; regAddr = 4'hC;
    waitSync();
    chk("R7 edge pulse hostIrq high", {15'h0, hostIrq}, 16'h1);
    chk("R4 edge line status bit4", regRdData, 16'h0010);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", {15'h0, hostIrq}, 16'h0);

    // R7 pulse inverts held level: level source on slot1 line0
    drv(); intReq[2] = 1'b1;
    waitSync();
    chk("R6 level held with edge bit set", {15'h0, hostIrq}, 16'h1);
    drv(); intReq[4] = 1'b0;
    waitSync();
    drv(); intReq[4] = 1'b1;
    waitSync();
    chk("R7 pulse inverts held level", {15'h0, hostIrq}, 16'h0);
    @(negedge clk);
    chk("R7 held level restored", {15'h0, hostIrq}, 16'h1);

    // R8 write-one clear of level bit
    wr(4'hC, 16'h0004);
    rd(4'hC, d); chk("R8 bit2 cleared, bit4 kept", d, 16'h0010);
    chk("R8 hostIrq drops after clear", {15'h0, hostIrq}, 16'h0);
    drv(); intReq[2] = 1'b0; intReq[4] = 1'b0;
    repeat (4) @(negedge clk);

    // R9 timeout set, clear, set-wins
    drv(); timeoutPulse[1] = 1'b1;
    drv(); timeoutPulse[1] = 1'b0;
    rd(4'hC, d); chk("R9 timeout bit13 set", d, 16'h2000);
    wr(4'hC, 16'h2000);
    rd(4'hC, d); chk("R9 timeout bit13 cleared", d, 16'h0000);
    drv(); timeoutPulse[3] = 1'b1; regAddr = 4'hC; regWrite = 1'b1; regWrData = 16'h8000;
    drv(); timeoutPulse[3] = 1'b0; regWrite = 1'b0;
    rd(4'hC, d); chk("R9 set wins over clear", d, 16'h8000);
    wr(4'hC, 16'h8000);

    // R10 error bits
    wr(4'hC, 16'h0F00);
    rd(4'hC, d); chk("R10 error bits read zero", d, 16'h0000);

    // Random phase, model compared every cycle (R2..R10)
    for (int c = 0; c < 3000; c++) begin
      drv();
      if ($urandom_range(0, 3) == 0) intReq[$urandom_range(0, 7)] ^= 1'b1;
      timeoutPulse = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'h0;
      regAddr = 4'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        regWrite  = 1'b1;
        regWrData = 16'($urandom);
      end else begin
        regWrite = 1'b0;
      end
    end
    drv(); regWrite = 1'b0;
    repeat (4) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule